// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Frames

This block turns parallel words into an asynchronous serial bit stream. A data frame is a low start bit, then 8 or 9 data bits least significant bit first, then one high stop bit. The word length comes from a mode input. Besides data frames, the block can send two special characters. An idle character holds the line high for one whole frame length. A break character holds it low for one whole frame length and is then followed by one extra high bit. Any parity is supplied by the caller as the top data bit. The block does not compute it.

Bit timing comes from a transmit-only divider. It raises a one-cycle tick every N system clocks, where N is taken from the divisor input. A request is accepted only while `busy` is low. At that moment the divisor, the mode and the data are all captured. When several requests arrive in the same cycle, a break request wins over an idle request, and an idle request wins over a data load.

The controller uses five named states. TX_IDLE is the rest state with the line high. TX_START sends the start position. TX_DATA sends the data positions. TX_STOP sends the stop position. TX_EXTRA sends the trailing high bit after a break.

The transitions are as follows. TX_IDLE moves to TX_START when a request is accepted. TX_START moves to TX_DATA on a tick. TX_DATA moves to TX_STOP on the tick that ends the last data bit. TX_STOP moves to TX_IDLE on a tick, or to TX_EXTRA on a tick if the frame is a break. TX_EXTRA moves to TX_IDLE on a tick.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` is high and `busy` is low.
- R2: A request (`load_valid`, `idle_req` or `break_req`) is accepted only on a clock edge where `busy` is low. `busy` rises in the cycle after acceptance. Requests made while `busy` is high do not change the frame in progress and start no frame afterwards.
- R3: A data frame or a break frame begins with `txd` low for one bit period, starting in the cycle after acceptance.
- R4: A data frame sends `load_data` least significant bit first. It sends 8 bits when `word9` is 0, and bit 8 of `load_data` is then ignored. It sends 9 bits when `word9` is 1. The mode is captured at acceptance.
- R5: A data frame ends with `txd` high for one bit period. `busy` falls right after that period, and the frame lasts (bits+2) bit periods in total.
- R6: An idle frame keeps `txd` high for (bits+2) bit periods while `busy` is high.
- R7: A break frame keeps `txd` low for (bits+2) bit periods. It is followed by one extra bit period with `txd` high, and then `busy` falls.
- R8: When requests arrive in the same cycle, a break request wins over an idle request, and an idle request wins over a data load.
- R9: Each bit period lasts `divisor` clock cycles, and a divisor of 0 acts as 1. The divisor is captured at acceptance, so changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | DIV_W | Clocks per bit, captured at acceptance |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| load_valid | input | 1 | Request a data frame |
| load_data | input | BASE_W+1 | Word to send; bit 0 goes first |
| idle_req | input | 1 | Request an idle frame |
| break_req | input | 1 | Request a break frame |
| busy | output | 1 | A frame is in progress; requests are ignored while high |
| txd | output | 1 | Serial line output, high at rest |

## Verification
The bench goes after the cases a designer most easily gets wrong:
- A divisor of 0 or 1 is used. A design that mishandles it stretches or skips bit periods.
- A 9-bit word is loaded in 8-bit mode. A design that does not mask the top bit leaks it into the frame or adds a data bit.
- Two or three requests arrive in the same cycle. A design with the wrong priority sends the wrong kind of frame.
- The extra high bit after a break is left out or doubled. This shows up as a frame one bit period short or long.
- The divisor changes while a frame is in flight, or a request arrives while `busy` is high. A design that re-samples the divisor, or latches the late request, changes the bit timing or starts a phantom frame after `busy` falls.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP,
        TX_EXTRA
    } tx_state_t;

    typedef enum logic [1:0] {
        FR_DATA,
        FR_IDLE,
        FR_BREAK
    } frame_kind_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // The divisor is captured only on restart, which happens while the transmitter is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
            cnt_q <= '0;
        end else if (restart) begin
            div_q <= (divisor == '0) ? DIV_W'(1) : divisor;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == div_q - DIV_W'(1));

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            word9,
    input  logic            load_valid,
    input  logic [BASE_W:0] load_data,
    input  logic            idle_req,
    input  logic            break_req,
    output logic            accept,
    output logic            busy,
    output logic            txd
);

    localparam int LONG_W = BASE_W + 1;
    localparam int CNT_W  = $clog2(LONG_W + 1);

    tx_state_t        state_q, state_d;
    frame_kind_t      kind_q;
    logic [BASE_W:0]  shreg_q;
    logic [CNT_W-1:0] left_q;

    assign accept = (state_q == TX_IDLE) && (load_valid || idle_req || break_req);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (accept) state_d = TX_START;
            TX_START: if (tick) state_d = TX_DATA;
            TX_DATA:  if (tick && left_q == CNT_W'(1)) state_d = TX_STOP;
            TX_STOP:  if (tick) state_d = (kind_q == FR_BREAK) ? TX_EXTRA : TX_IDLE;
            TX_EXTRA: if (tick) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // State register and frame datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            kind_q  <= FR_DATA;
            shreg_q <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= break_req ? FR_BREAK : (idle_req ? FR_IDLE : FR_DATA);
                shreg_q <= word9 ? load_data : {1'b0, load_data[BASE_W-1:0]};
                left_q  <= word9 ? CNT_W'(LONG_W) : CNT_W'(BASE_W);
            end else if (state_q == TX_DATA && tick) begin
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - CNT_W'(1);
            end
        end
    end

    // Outputs.
    always_comb begin
        busy = (state_q != TX_IDLE);
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = (kind_q == FR_IDLE);
            TX_DATA:  txd = (kind_q == FR_DATA) ? shreg_q[0] : (kind_q == FR_IDLE);
            TX_STOP:  txd = (kind_q != FR_BREAK);
            TX_EXTRA: txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int BASE_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             word9,
    input  logic             load_valid,
    input  logic [BASE_W:0]  load_data,
    input  logic             idle_req,
    input  logic             break_req,
    output logic             busy,
    output logic             txd
);

    logic tick;
    logic accept;

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (accept),
        .divisor (divisor),
        .tick    (tick)
    );

    sertx_fsm #(.BASE_W(BASE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .word9      (word9),
        .load_valid (load_valid),
        .load_data  (load_data),
        .idle_req   (idle_req),
        .break_req  (break_req),
        .accept     (accept),
        .busy       (busy),
        .txd        (txd)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic load_valid,
    input logic idle_req,
    input logic break_req,
    input logic busy,
    input logic txd
);

    assert_rest_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_start_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load_valid || idle_req || break_req));

    // Covers R3, and R8 because a break wins over a simultaneous idle request.
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && ($past(break_req) || !$past(idle_req))) |-> !txd);

    assert_idle_start_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(idle_req) && !$past(break_req)) |-> txd);

    assert_ends_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));

endmodule

bind sertx_top sertx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .idle_req   (idle_req),
    .break_req  (break_req),
    .busy       (busy),
    .txd        (txd)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;

    localparam int BASE_W = 8;
    localparam int DIV_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] divisor;
    logic             word9;
    logic             load_valid;
    logic [BASE_W:0]  load_data;
    logic             idle_req;
    logic             break_req;
    logic             busy;
    logic             txd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sertx_top #(.BASE_W(BASE_W), .DIV_W(DIV_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .divisor    (divisor),
        .word9      (word9),
        .load_valid (load_valid),
        .load_data  (load_data),
        .idle_req   (idle_req),
        .break_req  (break_req),
        .busy       (busy),
        .txd        (txd)
    );

    // Expected line level at bit position idx. kind: 0 data, 1 idle, 2 break.
    function automatic logic exp_bit(int kind, logic [8:0] d, int n, int idx);
        if (kind == 1) return 1'b1;
        if (kind == 2) return (idx < n + 2) ? 1'b0 : 1'b1;
        if (idx == 0) return 1'b0;
        if (idx <= n) return d[idx-1];
        return 1'b1;
    endfunction

    function automatic int exp_kind(logic lv, logic ir, logic br);
        if (br) return 2;
        if (ir) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic lv, input logic ir, input logic br,
                             input logic [8:0] d, input logic m, input int dv,
                             input bit perturb, input string tag);
        int kind  = exp_kind(lv, ir, br);
        int n     = m ? 9 : 8;
        int ediv  = (dv == 0) ? 1 : dv;
        int nbits = n + 2 + ((kind == 2) ? 1 : 0);
        int total = nbits * ediv;
        int bad_c = -1;
        int bad_a = 0;
        int bad_e = 0;
        @(negedge clk);
        divisor    = DIV_W'(dv);
        word9      = m;
        load_valid = lv;
        idle_req   = ir;
        break_req  = br;
        load_data  = d;
        @(negedge clk);
        load_valid = 1'b0;
        idle_req   = 1'b0;
        break_req  = 1'b0;
        for (int c = 0; c < total; c++) begin
            logic e = exp_bit(kind, d, n, c / ediv);
            if (bad_c < 0 && (txd !== e || busy !== 1'b1)) begin
                bad_c = c;
                bad_a = {busy, txd};
                bad_e = {1'b1, e};
            end
            if (perturb && c == 1) begin
                divisor    = DIV_W'(dv + 3);
                word9      = ~m;
                load_valid = 1'b1;
                break_req  = 1'b1;
                load_data  = ~d;
            end
            if (perturb && c == 2) begin
                load_valid = 1'b0;
                break_req  = 1'b0;
            end
            @(negedge clk);
        end
        if (bad_c >= 0) $display("  (mismatch at cycle %0d of frame, {busy,txd})", bad_c);
        check(bad_c < 0, tag, bad_a, bad_e);
        check(busy === 1'b0 && txd === 1'b1, perturb ? "R2" : "R5", {busy, txd}, 1);
        @(negedge clk);
        check(busy === 1'b0, perturb ? "R2" : "R5", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0; divisor = '0; word9 = 1'b0; load_valid = 1'b0;
        load_data = '0; idle_req = 1'b0; break_req = 1'b0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && txd === 1'b1, "R1", {busy, txd}, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && txd === 1'b1, "R1", {busy, txd}, 1);

        run_frame(1, 0, 0, 9'h1A5, 0, 1, 0, "R4");   // top bit ignored in 8-bit mode
        run_frame(1, 0, 0, 9'h0C3, 0, 0, 0, "R9");   // divisor 0 acts as 1
        run_frame(1, 0, 0, 9'h155, 1, 3, 0, "R4");   // 9-bit mode
        run_frame(1, 0, 0, 9'h100, 1, 2, 0, "R3");
        run_frame(0, 1, 0, 9'h000, 0, 2, 0, "R6");
        run_frame(0, 0, 1, 9'h1FF, 1, 2, 0, "R7");
        run_frame(0, 0, 1, 9'h0FF, 0, 1, 0, "R7");
        run_frame(1, 1, 1, 9'h0AA, 0, 2, 0, "R8");   // break wins
        run_frame(1, 1, 0, 9'h055, 1, 1, 0, "R8");   // idle wins over data
        run_frame(1, 0, 0, 9'h03C, 0, 4, 1, "R9");   // divisor change mid-frame
        run_frame(0, 1, 0, 9'h000, 1, 1, 1, "R2");   // requests while busy

        for (int i = 0; i < 40; i++) begin
            logic lv = 1'($urandom);
            logic ir = 1'($urandom);
            logic br = 1'($urandom);
            if (!lv && !ir && !br) lv = 1'b1;
            run_frame(lv, ir, br, 9'($urandom), 1'($urandom), int'($urandom % 7),
                      ($urandom % 4) == 0, br ? "R7" : (ir ? "R6" : "R4"));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule